// File: doc/BRIEF.md
# DDR Write-Port Client

This block sits between user logic and the local write side of a DDR memory controller. User logic hands it write jobs, each an address and a burst count, over a valid/ready handshake. The block holds one job and raises the controller write request only in cycles where the controller reports that it is not busy. It keeps a record of how many data words each issued request still owes, and answers each data strobe from the controller with one 288-bit word.

Each word holds four 72-bit beats, one per DDR clock edge, aimed at consecutive column addresses. The controller sends an early data strobe three cycles ahead of its normal data strobe. A mode input picks the timing. In early timing, the word goes out in the cycle after the early strobe is sampled. In late timing, the word goes out in the cycle the normal strobe would occupy, and that cycle is found by delaying the early strobe. Payload words come from the user through a separate fetch handshake. They are prefetched into a two-word buffer, so a strobe never has to reach back to the user within the same cycle.

Top module: `ddr_wr_client`

## Requirements
- R1: While reset is held and in the first cycle after it, `mc_wr_req` is 0, `mc_wdata` is 0, `strobe_err` is 0, `job_ready` is 1 and `fetch_ready` is 1.
- R2: `mc_wr_req` is high only in cycles where `mc_busy` is low. A request is taken at the clock edge where `mc_wr_req` is high. Until that edge, the address and burst outputs stay stable, and after it the request drops.
- R3: While `mc_wr_req` is high, `mc_addr` and `mc_burst` equal the address and burst count of the job being issued.
- R4: An issued request owes twice its burst count in data words (two words per eight-transfer burst). A burst count of zero is handled as one burst.
- R5: With `late_mode` = 0, a word is driven on `mc_wdata` in the cycle right after the clock edge that samples `mc_early_strobe` high.
- R6: With `late_mode` = 1, the word for an early strobe sampled at edge k is driven in the cycle after edge k+2, which is three cycles after the early strobe was raised.
- R7: Words leave in the order they were fetched. Bits [72k+71:72k] of a word (k = 0..3) carry the beat for column + k, passed through unchanged.
- R8: In every cycle that does not carry a word, `mc_wdata` is all zeros.
- R9: A strobe that arrives while no word is owed, or while no prefetched word is held, drives no word and sets `strobe_err`. The flag then stays high until reset.
- R10: Strobes on consecutive cycles each receive a word. `fetch_ready` is high whenever fewer than two words are buffered, and it depends on no strobe input.
- R11: At most four requests (parameter JOBS) are outstanding. While four are owed, `mc_wr_req` stays low. The held job is issued once the oldest request's last word has been sent.
- R12: A synchronous reset in mid-stream clears all owed counts, the held job, the request and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| late_mode | input | 1 | 0 = drive word after early strobe, 1 = drive word at normal-strobe time |
| job_valid | input | 1 | A write job is offered |
| job_ready | output | 1 | The job holding register is free |
| job_addr | input | 34 | Job start address |
| job_bsize | input | 8 | Job burst count |
| fetch_valid | input | 1 | The user offers a payload word |
| fetch_ready | output | 1 | The prefetch buffer has room |
| fetch_data | input | 288 | Payload word, four 72-bit beats |
| mc_busy | input | 1 | Controller busy, aligned |
| mc_wr_req | output | 1 | Write request to the controller |
| mc_addr | output | 34 | Request address |
| mc_burst | output | 8 | Request burst count |
| mc_early_strobe | input | 1 | Early data-request strobe |
| mc_wdata | output | 288 | Write data word to the controller |
| strobe_err | output | 1 | Sticky flag: a strobe arrived with nothing owed or buffered |

## Verification
The bench runs strobes back to back in both timing modes. A design that answered from the late strobe without a prefetch word, or that used the wrong delay tap, shows up in two ways: the word lands a cycle early or late, and a nonzero value appears where zero is expected. A zero burst count, and strobes that outnumber the owed words, test the owed-word arithmetic. A miscount there either leaves the error flag low or drives an extra word. The bench also fills the outstanding-request list and then raises a reset in mid-stream. A design with a wrong full test or an incomplete reset would issue a fifth request, or would still answer a strobe after the reset.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;
  localparam int DEF_ADDR_W = 34;
  localparam int DEF_BSZ_W  = 8;
  localparam int DEF_BEAT_W = 72;
  localparam int DEF_BEATS  = 4;
  localparam int DEF_JOBS   = 4;
  localparam int DEF_LEAD   = 3;

  typedef enum logic {
    MODE_EARLY = 1'b0,
    MODE_LATE  = 1'b1
  } strobe_mode_e;
endpackage

// File: rtl/ddr_wr_job_stage.sv
module ddr_wr_job_stage #(
  parameter int ADDR_W = 34,
  parameter int BSZ_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              job_valid,
  output logic              job_ready,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [BSZ_W-1:0]  job_bsize,
  input  logic              mc_busy,
  input  logic              slot_free,
  output logic              mc_wr_req,
  output logic [ADDR_W-1:0] mc_addr,
  output logic [BSZ_W-1:0]  mc_burst,
  output logic              hold_valid,
  output logic              req_fire
);
  logic [ADDR_W-1:0] addr_q;
  logic [BSZ_W-1:0]  bsize_q;

  assign job_ready = !hold_valid;
  assign mc_wr_req = hold_valid && !mc_busy && slot_free;
  assign req_fire  = mc_wr_req;
  assign mc_addr   = addr_q;
  assign mc_burst  = bsize_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      addr_q     <= '0;
      bsize_q    <= '0;
    end else if (!hold_valid && job_valid) begin
      hold_valid <= 1'b1;
      addr_q     <= job_addr;
      bsize_q    <= job_bsize;
    end else if (req_fire) begin
      hold_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_wr_owed_fifo.sv
module ddr_wr_owed_fifo #(
  parameter int BSZ_W = 8,
  parameter int JOBS  = 4,
  localparam int CNT_W = BSZ_W + 1,
  localparam int PTR_W = (JOBS > 1) ? $clog2(JOBS) : 1,
  localparam int LVL_W = $clog2(JOBS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [BSZ_W-1:0] push_bsize,
  input  logic             spend,
  output logic             slot_free,
  output logic             owed_any,
  output logic [LVL_W-1:0] level,
  output logic             retire
);
  function automatic logic [CNT_W-1:0] words_owed(input logic [BSZ_W-1:0] b);
    logic [CNT_W-1:0] n;
    n = (b == '0) ? CNT_W'(1) : CNT_W'(b);
    return n << 1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(JOBS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [CNT_W-1:0] owed_mem [JOBS];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] used;
  logic             push_ok, consume;

  assign owed_any  = (level != '0);
  assign slot_free = (level != LVL_W'(JOBS));
  assign push_ok   = push && slot_free;
  assign consume   = spend && owed_any;
  assign retire    = consume && ((used + 1'b1) == owed_mem[rd_ptr]);

  always_ff @(posedge clk) begin
    if (push_ok) owed_mem[wr_ptr] <= words_owed(push_bsize);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (consume) begin
        if (retire) begin
          used   <= '0;
          rd_ptr <= ptr_next(rd_ptr);
        end else begin
          used <= used + 1'b1;
        end
      end
      level <= level + LVL_W'(push_ok) - LVL_W'(retire);
    end
  end
endmodule

// File: rtl/ddr_wr_prefetch.sv
module ddr_wr_prefetch #(
  parameter int WORD_W = 288
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [WORD_W-1:0] fetch_data,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic              have_word
);
  logic [WORD_W-1:0] slot [2];
  logic              wr_sel, rd_sel;
  logic [1:0]        cnt;
  logic              load, take;

  assign fetch_ready = (cnt != 2'd2);
  assign have_word   = (cnt != 2'd0);
  assign load        = fetch_valid && fetch_ready;
  assign take        = pop && have_word;
  assign head        = slot[rd_sel];

  always_ff @(posedge clk) begin
    if (load) slot[wr_sel] <= fetch_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sel <= 1'b0;
      rd_sel <= 1'b0;
      cnt    <= 2'd0;
    end else begin
      if (load) wr_sel <= !wr_sel;
      if (take) rd_sel <= !rd_sel;
      cnt <= cnt + 2'(load) - 2'(take);
    end
  end
endmodule

// File: rtl/ddr_wr_strobe_align.sv
module ddr_wr_strobe_align
  import ddr_wr_pkg::*;
#(
  parameter int LEAD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic early_strobe,
  input  logic late_mode,
  output logic take
);
  strobe_mode_e mode;
  assign mode = strobe_mode_e'(late_mode);

  generate
    if (LEAD < 2) begin : g_direct
      assign take = early_strobe;
    end else begin : g_line
      logic [LEAD-2:0] dly;
      always_ff @(posedge clk) begin
        if (rst) dly[0] <= 1'b0;
        else     dly[0] <= early_strobe;
      end
      for (genvar i = 1; i < LEAD - 1; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) dly[i] <= 1'b0;
          else     dly[i] <= dly[i-1];
        end
      end
      assign take = (mode == MODE_LATE) ? dly[LEAD-2] : early_strobe;
    end
  endgenerate
endmodule

// File: rtl/ddr_wr_client.sv
module ddr_wr_client
  import ddr_wr_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BSZ_W  = DEF_BSZ_W,
  parameter int BEAT_W = DEF_BEAT_W,
  parameter int BEATS  = DEF_BEATS,
  parameter int JOBS   = DEF_JOBS,
  parameter int LEAD   = DEF_LEAD,
  localparam int WORD_W = BEAT_W * BEATS,
  localparam int LVL_W  = $clog2(JOBS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              late_mode,
  input  logic              job_valid,
  output logic              job_ready,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [BSZ_W-1:0]  job_bsize,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [WORD_W-1:0] fetch_data,
  input  logic              mc_busy,
  output logic              mc_wr_req,
  output logic [ADDR_W-1:0] mc_addr,
  output logic [BSZ_W-1:0]  mc_burst,
  input  logic              mc_early_strobe,
  output logic [WORD_W-1:0] mc_wdata,
  output logic              strobe_err
);
  logic              hold_valid, req_fire, slot_free;
  logic              owed_any, retire, take, have_word, word_go;
  logic [LVL_W-1:0]  owed_level;
  logic [WORD_W-1:0] pf_head;

  ddr_wr_job_stage #(.ADDR_W(ADDR_W), .BSZ_W(BSZ_W)) u_job (
    .clk(clk), .rst(rst),
    .job_valid(job_valid), .job_ready(job_ready),
    .job_addr(job_addr), .job_bsize(job_bsize),
    .mc_busy(mc_busy), .slot_free(slot_free),
    .mc_wr_req(mc_wr_req), .mc_addr(mc_addr), .mc_burst(mc_burst),
    .hold_valid(hold_valid), .req_fire(req_fire)
  );

  ddr_wr_owed_fifo #(.BSZ_W(BSZ_W), .JOBS(JOBS)) u_owed (
    .clk(clk), .rst(rst),
    .push(req_fire), .push_bsize(mc_burst),
    .spend(word_go),
    .slot_free(slot_free), .owed_any(owed_any),
    .level(owed_level), .retire(retire)
  );

  ddr_wr_prefetch #(.WORD_W(WORD_W)) u_pf (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_data(fetch_data),
    .pop(word_go), .head(pf_head), .have_word(have_word)
  );

  ddr_wr_strobe_align #(.LEAD(LEAD)) u_align (
    .clk(clk), .rst(rst),
    .early_strobe(mc_early_strobe), .late_mode(late_mode),
    .take(take)
  );

  assign word_go = take && owed_any && have_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_wdata   <= '0;
      strobe_err <= 1'b0;
    end else begin
      mc_wdata <= word_go ? pf_head : '0;
      if (take && !word_go) strobe_err <= 1'b1;
    end
  end
endmodule

// File: rtl/ddr_wr_client_chk.sv
module ddr_wr_client_chk #(
  parameter int ADDR_W = 34,
  parameter int BSZ_W  = 8,
  parameter int WORD_W = 288,
  parameter int JOBS   = 4,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mc_busy,
  input logic              mc_wr_req,
  input logic [ADDR_W-1:0] mc_addr,
  input logic [BSZ_W-1:0]  mc_burst,
  input logic              hold_valid,
  input logic              req_fire,
  input logic              word_go,
  input logic              take,
  input logic              owed_any,
  input logic [LVL_W-1:0]  owed_level,
  input logic [WORD_W-1:0] mc_wdata,
  input logic              strobe_err
);
  assert_req_idle_busy_R2: assert property (@(posedge clk) disable iff (rst)
    mc_wr_req |-> !mc_busy);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_valid && !req_fire) |=> ($stable(mc_addr) && $stable(mc_burst)));

  assert_bus_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !word_go |=> (mc_wdata == '0));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    strobe_err |=> strobe_err);

  assert_orphan_err_R9: assert property (@(posedge clk) disable iff (rst)
    (take && !owed_any) |=> strobe_err);

  assert_occupancy_R11: assert property (@(posedge clk) disable iff (rst)
    (owed_level == LVL_W'(JOBS)) |-> !mc_wr_req);
endmodule

bind ddr_wr_client ddr_wr_client_chk #(
  .ADDR_W(ADDR_W), .BSZ_W(BSZ_W), .WORD_W(WORD_W), .JOBS(JOBS), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .mc_busy(mc_busy), .mc_wr_req(mc_wr_req),
  .mc_addr(mc_addr), .mc_burst(mc_burst), .hold_valid(hold_valid),
  .req_fire(req_fire), .word_go(word_go), .take(take), .owed_any(owed_any),
  .owed_level(owed_level), .mc_wdata(mc_wdata), .strobe_err(strobe_err)
);

// File: tb/ddr_wr_client_test.sv
module ddr_wr_client_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         late_mode = 1'b0;
  logic         job_valid = 1'b0;
  logic         job_ready;
  logic [33:0]  job_addr = '0;
  logic [7:0]   job_bsize = '0;
  logic         fetch_valid = 1'b0;
  logic         fetch_ready;
  logic [287:0] fetch_data;
  logic         mc_busy = 1'b0;
  logic         mc_wr_req;
  logic [33:0]  mc_addr;
  logic [7:0]   mc_burst;
  logic         mc_early_strobe = 1'b0;
  logic [287:0] mc_wdata;
  logic         strobe_err;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  int feed_seq = 1;
  bit adv = 1'b0;
  logic [287:0] sb [$];
  int           tq [$];

  always #2.5 clk = !clk;

  ddr_wr_client uut (
    .clk(clk), .rst(rst), .late_mode(late_mode),
    .job_valid(job_valid), .job_ready(job_ready),
    .job_addr(job_addr), .job_bsize(job_bsize),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_data(fetch_data),
    .mc_busy(mc_busy), .mc_wr_req(mc_wr_req), .mc_addr(mc_addr), .mc_burst(mc_burst),
    .mc_early_strobe(mc_early_strobe), .mc_wdata(mc_wdata), .strobe_err(strobe_err)
  );

  function automatic logic [287:0] mkword(input int s);
    logic [287:0] w;
    for (int k = 0; k < 4; k++) w[72*k +: 72] = {8'(k + 1), 48'h0, 16'(s)};
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [287:0] act, input logic [287:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // feeder: advance the offered word after each accepted transfer
  initial fetch_data = mkword(1);
  always @(posedge clk) begin
    #1;
    if (adv) begin
      feed_seq++;
      fetch_data = mkword(feed_seq);
      adv = 1'b0;
    end
  end

  // monitor: record fetched words, compare words on the bus against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (fetch_valid && fetch_ready) begin
        sb.push_back(fetch_data);
        adv = 1'b1;
      end
      if (tq.size() > 0 && tq[0] == cyc) begin
        void'(tq.pop_front());
        if (sb.size() == 0) begin
          chk(1'b0, "R7 word expected but scoreboard empty", mc_wdata, '0);
        end else begin
          logic [287:0] exp;
          exp = sb.pop_front();
          chk(mc_wdata == exp, late_mode ? "R6 late word" : "R5 early word", mc_wdata, exp);
          for (int k = 0; k < 4; k++)
            chk(mc_wdata[72*k +: 72] == exp[72*k +: 72], "R7 beat lane", mc_wdata[72*k +: 72], exp[72*k +: 72]);
        end
      end else begin
        chk(mc_wdata == '0, "R8 idle bus zero", mc_wdata, '0);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input bit mode);
    @(posedge clk); #1;
    rst = 1'b1; fetch_valid = 1'b0; job_valid = 1'b0;
    mc_early_strobe = 1'b0; mc_busy = 1'b0; late_mode = mode;
    repeat (3) @(posedge clk);
    #1;
    sb.delete(); tq.delete();
    rst = 1'b0; fetch_valid = 1'b1;
  endtask

  task automatic push_job(input logic [33:0] a, input logic [7:0] b);
    @(posedge clk); #1;
    job_valid = 1'b1; job_addr = a; job_bsize = b;
    @(negedge clk);
    while (!job_ready) @(negedge clk);
    @(posedge clk); #1;
    job_valid = 1'b0;
  endtask

  task automatic wait_issue(input logic [33:0] a, input logic [7:0] b, input string tag);
    int n = 0;
    @(negedge clk);
    while (!mc_wr_req && n < 12) begin n++; @(negedge clk); end
    chk(mc_wr_req, tag, 288'(mc_wr_req), 288'(1));
    chk(mc_addr == a, "R3 request address", 288'(mc_addr), 288'(a));
    chk(mc_burst == b, "R3 request burst", 288'(mc_burst), 288'(b));
    @(posedge clk); #1;
  endtask

  task automatic strobes(input int n, input int n_exp);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      mc_early_strobe = 1'b1;
      if (i < n_exp) tq.push_back(cyc + (late_mode ? 3 : 1));
    end
    @(posedge clk); #1;
    mc_early_strobe = 1'b0;
  endtask

  task automatic drained(input string tag);
    chk(tq.size() == 0, tag, 288'(tq.size()), 288'(0));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not end, actual cycle %0d expected under 5000", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!mc_wr_req, "R1 request low in reset", 288'(mc_wr_req), 288'(0));
    chk(mc_wdata == '0, "R1 data zero in reset", mc_wdata, '0);
    chk(!strobe_err, "R1 error clear", 288'(strobe_err), 288'(0));
    chk(job_ready, "R1 job_ready high", 288'(job_ready), 288'(1));
    chk(fetch_ready, "R1 fetch_ready high", 288'(fetch_ready), 288'(1));
    @(posedge clk); #1;
    rst = 1'b0; fetch_valid = 1'b1;
    @(negedge clk);
    chk(!mc_wr_req && !strobe_err && job_ready, "R1 state after reset", 288'({mc_wr_req, strobe_err, job_ready}), 288'(3'b001));

    // R2/R3: request held back while busy
    mc_busy = 1'b1;
    push_job(34'h2_1234_5678, 8'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!mc_wr_req, "R2 no request while busy", 288'(mc_wr_req), 288'(0));
    end
    @(posedge clk); #1;
    mc_busy = 1'b0;
    wait_issue(34'h2_1234_5678, 8'd1, "R2 request after busy drops");
    @(negedge clk);
    chk(!mc_wr_req, "R2 request drops after acceptance", 288'(mc_wr_req), 288'(0));

    // R5/R10 early mode, back-to-back strobes
    strobes(2, 2);
    idle(6);
    drained("R10 both back-to-back words delivered");
    chk(!strobe_err, "R5 no error on owed strobes", 288'(strobe_err), 288'(0));

    // R9 orphan strobe
    strobes(1, 0);
    idle(3);
    chk(strobe_err, "R9 error on unowed strobe", 288'(strobe_err), 288'(1));
    idle(4);
    chk(strobe_err, "R9 error stays set", 288'(strobe_err), 288'(1));

    // R12 reset mid-stream
    push_job(34'h0_0000_0100, 8'd3);
    wait_issue(34'h0_0000_0100, 8'd3, "R12 request before reset");
    do_reset(1'b0);
    @(negedge clk);
    chk(!strobe_err, "R12 error cleared", 288'(strobe_err), 288'(0));
    chk(!mc_wr_req, "R12 request cleared", 288'(mc_wr_req), 288'(0));
    strobes(1, 0);
    idle(4);
    chk(strobe_err, "R12 owed counts cleared", 288'(strobe_err), 288'(1));

    // R6 late mode
    do_reset(1'b1);
    push_job(34'h3_ffff_0000, 8'd2);
    wait_issue(34'h3_ffff_0000, 8'd2, "R6 request issued");
    strobes(1, 1);
    idle(2);
    strobes(2, 2);
    idle(2);
    strobes(1, 1);
    idle(6);
    drained("R6 late words delivered");
    chk(!strobe_err, "R6 no error", 288'(strobe_err), 288'(0));

    // R4 burst count zero owes two words
    push_job(34'h1_0000_0040, 8'd0);
    wait_issue(34'h1_0000_0040, 8'd0, "R4 zero-size request");
    strobes(2, 2);
    idle(6);
    drained("R4 two words for zero size");
    chk(!strobe_err, "R4 no error within two words", 288'(strobe_err), 288'(0));
    strobes(1, 0);
    idle(6);
    chk(strobe_err, "R4 third strobe owes nothing", 288'(strobe_err), 288'(1));

    // R11 outstanding limit
    do_reset(1'b0);
    for (int j = 0; j < 4; j++) begin
      push_job(34'(j * 16), 8'd1);
      wait_issue(34'(j * 16), 8'd1, "R11 request within limit");
    end
    push_job(34'h0_0000_0400, 8'd1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!mc_wr_req, "R11 no request while full", 288'(mc_wr_req), 288'(0));
    end
    strobes(2, 2);
    wait_issue(34'h0_0000_0400, 8'd1, "R11 request after retire");
    strobes(8, 8);
    idle(6);
    drained("R11 all owed words delivered");
    chk(!strobe_err, "R11 no error", 288'(strobe_err), 288'(0));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule